// File: doc/BRIEF.md
# Two-Wire Target with Region-Wrapping Byte Pointer

This block is a two-wire serial bus target in front of a small internal byte store. The store has two regions: a register region at addresses 0x00 to 0x1F and a scratch region at 0x20 to 0x5F. The target watches the bus for Start, repeated Start and Stop, answers to one fixed 7-bit device address, and acknowledges. It then either takes bytes from the controller or shifts bytes out to it.

All accesses go through one internal byte pointer. The pointer keeps its value from one transaction to the next. A read with no address phase therefore carries on from the byte after the last one touched. When the pointer steps past the end of a region, it returns to the start of that same region; it never runs into the other region.

A controller sets the pointer with a write transaction that carries one address byte. That write may continue with data bytes, or it may be cut short by a repeated Start followed by a read. The target pulls SDA low through an output enable and never drives it high.

Top module: `i2c_seg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every store byte is 0x00 and the pointer is 0x00, so a first read with no address phase returns the byte at 0x00.
- R2: A control byte whose upper seven bits are 1101111 is acknowledged: 0xDE selects a write and 0xDF a read. A control byte with any other address gets no acknowledge, and `sda_oe` stays 0 for the rest of that transaction.
- R3: In a read, the byte at the pointer is shifted out most significant bit first, one bit per SCL period, starting right after the acknowledge.
- R4: A read with no address phase that follows an access to address n returns the byte at the address after n, following the wrap rule of R7.
- R5: Random read: write control byte, address byte (acknowledged), repeated Start, read control byte. The read returns the byte at the address just written.
- R6: After each byte sent, an acknowledge from the controller makes the target send the next byte. A no-acknowledge followed by Stop ends the transfer, with SDA released.
- R7: The pointer steps from 0x1F to 0x00 and from 0x5F to 0x20, on reads and on writes alike.
- R8: An address byte of 0x60 or above gets no acknowledge and leaves the pointer unchanged.
- R9: In a write, every data byte after the address byte is stored at the pointer and acknowledged, and the pointer then advances.
- R10: A Start or Stop abandons any byte in progress and releases SDA. A partly received data byte is not stored, and a control byte that follows a repeated Start is handled normally.
- R11: The target changes its SDA drive only while the synchronised SCL is low. Received bits are taken on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled against it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA to 0; when 0, SDA is released |

## Verification
Two functions can fall on the same bus event: the byte shifter, which takes a data bit on an SCL rising edge, and the Start detector, which reacts to SDA falling while SCL is high inside that same high phase. The bench provokes this by sending the address byte of a write, then some bits of a data byte, then a repeated Start and a read control byte. The bench judges the outcome in two ways. The read control byte must be acknowledged. The bytes read back must show that the partial data byte was never stored. A Stop issued part way through a data byte is judged in the same way, by reading the target address back afterwards.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_ADDR,
    PH_DATA
  } ph_e;

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else if (g == 0) pipe[g] <= d_i;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/i2cst_ptr_step.sv
module i2cst_ptr_step #(
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64,
  parameter int AW        = 7
) (
  input  logic [AW-1:0] cur_i,
  output logic [AW-1:0] nxt_o
);

  localparam logic [AW-1:0] REG_LAST  = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] RAM_FIRST = AW'(REG_BYTES);
  localparam logic [AW-1:0] RAM_LAST  = AW'(REG_BYTES + RAM_BYTES - 1);

  always_comb begin
    if (cur_i == REG_LAST)      nxt_o = '0;
    else if (cur_i == RAM_LAST) nxt_o = RAM_FIRST;
    else                        nxt_o = cur_i + 1'b1;
  end

endmodule

// File: rtl/i2cst_store.sv
module i2cst_store #(
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/i2c_seg_target.sv
module i2c_seg_target #(
  parameter logic [6:0] DEV_ADDR  = 7'b1101111,
  parameter int         REG_BYTES = 32,
  parameter int         RAM_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  import i2cst_pkg::*;

  localparam int TOTAL = REG_BYTES + RAM_BYTES;
  localparam int AW    = $clog2(TOTAL);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // line synchronisers and edge/condition detection
  logic scl_s, sda_s, scl_q, sda_q;
  i2cst_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

  // state
  st_e           state, state_d;
  ph_e           phase, phase_d;
  logic [7:0]    shreg, shreg_d;
  logic [3:0]    cnt, cnt_d;
  logic          oe, oe_d;
  logic          is_rd, is_rd_d;
  logic          mack, mack_d;
  logic [AW-1:0] ptr, ptr_d, ptr_inc;
  logic          we, ptr_adv;
  logic [7:0]    rd_byte;

  i2cst_store #(.DEPTH(TOTAL), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (we),
    .addr_i  (ptr),
    .wdata_i (shreg),
    .rdata_o (rd_byte)
  );

  i2cst_ptr_step #(.REG_BYTES(REG_BYTES), .RAM_BYTES(RAM_BYTES), .AW(AW)) u_step (
    .cur_i (ptr),
    .nxt_o (ptr_inc)
  );

  // next-state logic
  always_comb begin
    state_d = state;
    phase_d = phase;
    shreg_d = shreg;
    cnt_d   = cnt;
    oe_d    = oe;
    is_rd_d = is_rd;
    mack_d  = mack;
    ptr_d   = ptr;
    we      = 1'b0;
    ptr_adv = 1'b0;

    if (start_det) begin
      state_d = ST_RX;
      phase_d = PH_CTRL;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg_d = {shreg[6:0], sda_s};
            cnt_d   = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_d = 4'd0;
            case (phase)
              PH_CTRL: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  is_rd_d = shreg[0];
                  oe_d    = 1'b1;
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              PH_ADDR: begin
                if (int'(shreg) < TOTAL) begin
                  ptr_d   = shreg[AW-1:0];
                  oe_d    = 1'b1;
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              default: begin
                we      = 1'b1;
                ptr_d   = ptr_inc;
                ptr_adv = 1'b1;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (phase == PH_CTRL && is_rd) begin
              shreg_d = rd_byte;
              oe_d    = ~rd_byte[7];
              cnt_d   = 4'd1;
              ptr_d   = ptr_inc;
              ptr_adv = 1'b1;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RX;
              phase_d = (phase == PH_CTRL) ? PH_ADDR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_d    = 1'b0;
              cnt_d   = 4'd0;
              state_d = ST_MACK;
            end else begin
              shreg_d = {shreg[6:0], 1'b0};
              oe_d    = ~shreg[6];
              cnt_d   = cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              shreg_d = rd_byte;
              oe_d    = ~rd_byte[7];
              cnt_d   = 4'd1;
              ptr_d   = ptr_inc;
              ptr_adv = 1'b1;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state <= ST_IDLE;
      phase <= PH_CTRL;
      shreg <= 8'h00;
      cnt   <= 4'd0;
      oe    <= 1'b0;
      is_rd <= 1'b0;
      mack  <= 1'b0;
      ptr   <= '0;
    end else begin
      state <= state_d;
      phase <= phase_d;
      shreg <= shreg_d;
      cnt   <= cnt_d;
      oe    <= oe_d;
      is_rd <= is_rd_d;
      mack  <= mack_d;
      ptr   <= ptr_d;
    end
  end

  assign sda_oe = oe;

endmodule

// File: rtl/i2cst_chk.sv
module i2cst_chk
  import i2cst_pkg::*;
#(
  parameter int AW        = 7,
  parameter int REG_BYTES = 32,
  parameter int TOTAL     = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input st_e           state,
  input logic [AW-1:0] ptr,
  input logic          ptr_adv,
  input logic          we
);

  a_r11_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  a_r10_start_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX && !sda_oe));

  a_r7_ptr_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < TOTAL);

  a_r7_step_keeps_region: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> ((int'(ptr) < REG_BYTES) == (int'($past(ptr)) < REG_BYTES)));

  a_r9_store_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> state == ST_RX);

endmodule

bind i2c_seg_target i2cst_chk #(.AW(AW), .REG_BYTES(REG_BYTES), .TOTAL(TOTAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state),
  .ptr       (ptr),
  .ptr_adv   (ptr_adv),
  .we        (we)
);

// File: tb/test_i2c_seg_target.sv
module test_i2c_seg_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl;
  logic m_sda;
  logic sda_oe;
  logic sda_bus;

  int n_chk  = 0;
  int n_fail = 0;
  int r11_bad = 0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_seg_target i_i2c_seg_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  // R11 monitor: pull-down must only begin while SCL is low
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && m_scl) r11_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    wait_q();
    m_scl = 1'b1; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    b = sda_bus;
    repeat (Q/2) @(negedge clk);
    m_scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~more);
  endtask

  // write n bytes starting at addr; checks acks
  task automatic write_block(input logic [7:0] addr, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int n);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(8'hDE, ack); chk("R2 write control ack", int'(ack), 1);
    send_byte(addr, ack);  chk("R9 address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk("R9 data ack", int'(ack), 1);
    end
    bus_stop();
  endtask

  task automatic set_ptr_and_read_ctrl(input logic [7:0] addr);
    logic ack;
    bus_start();
    send_byte(8'hDE, ack); chk("R5 control ack", int'(ack), 1);
    send_byte(addr, ack);  chk("R5 address ack", int'(ack), 1);
    bus_start();
    send_byte(8'hDF, ack); chk("R5 read control ack", int'(ack), 1);
  endtask

  task automatic t_reset();
    logic ack;
    logic [7:0] v;
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    bus_start();
    send_byte(8'hDF, ack); chk("R1 read control ack", int'(ack), 1);
    recv_byte(1'b0, v);    chk("R1 byte at 0x00", int'(v), 8'h00);
    bus_stop();
    chk("R6 released after stop", int'(sda_oe), 0);
  endtask

  task automatic t_foreign();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R2 foreign address not acked", int'(ack), 0);
    send_byte(8'h00, ack); chk("R2 silent after foreign address", int'(ack), 0);
    chk("R2 sda_oe low", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic t_reg_region();
    logic [7:0] v;
    logic [7:0] d [3];
    // 0x1E,0x1F, then wrap to 0x00
    write_block(8'h1E, 8'h11, 8'h22, 8'h33, 3);
    write_block(8'h01, 8'h44, 8'h00, 8'h00, 1);
    set_ptr_and_read_ctrl(8'h1E);
    for (int i = 0; i < 3; i++) recv_byte(i != 2, d[i]);
    bus_stop();
    chk("R5 first byte at 0x1E", int'(d[0]), 8'h11);
    chk("R6 sequential byte at 0x1F", int'(d[1]), 8'h22);
    chk("R7 wrap 0x1F to 0x00", int'(d[2]), 8'h33);
    chk("R6 released after NACK and stop", int'(sda_oe), 0);
    // current-address read continues at 0x01
    begin
      logic ack;
      bus_start();
      send_byte(8'hDF, ack); chk("R4 control ack", int'(ack), 1);
      recv_byte(1'b0, v);    chk("R4 current address byte 0x01", int'(v), 8'h44);
      bus_stop();
    end
  endtask

  task automatic t_ram_region();
    logic ack;
    logic [7:0] a, b, c;
    write_block(8'h5F, 8'hA5, 8'h5A, 8'hC3, 3);
    set_ptr_and_read_ctrl(8'h5F);
    recv_byte(1'b1, a);
    recv_byte(1'b0, b);
    bus_stop();
    chk("R3 byte at 0x5F msb first", int'(a), 8'hA5);
    chk("R7 wrap 0x5F to 0x20", int'(b), 8'h5A);
    bus_start();
    send_byte(8'hDF, ack);
    recv_byte(1'b0, c);
    bus_stop();
    chk("R4 current read at 0x21", int'(c), 8'hC3);
  endtask

  task automatic t_bad_addr();
    logic ack;
    logic [7:0] v;
    set_ptr_and_read_ctrl(8'h1E);
    recv_byte(1'b0, v);
    bus_stop();
    chk("R5 single byte at 0x1E", int'(v), 8'h11);
    bus_start();
    send_byte(8'hDE, ack); chk("R2 control ack", int'(ack), 1);
    send_byte(8'h60, ack); chk("R8 address 0x60 not acked", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'hDF, ack);
    recv_byte(1'b0, v);
    bus_stop();
    chk("R8 pointer kept at 0x1F", int'(v), 8'h22);
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] v;
    // Stop in the middle of a data byte
    bus_start();
    send_byte(8'hDE, ack);
    send_byte(8'h10, ack); chk("R9 address 0x10 ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    chk("R10 released after stop", int'(sda_oe), 0);
    // repeated Start in the middle of a data byte
    bus_start();
    send_byte(8'hDE, ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    send_byte(8'hDF, ack); chk("R10 control after repeated start", int'(ack), 1);
    recv_byte(1'b0, v);
    bus_stop();
    chk("R10 partial byte not stored", int'(v), 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_foreign();
    t_reg_region();
    t_ram_region();
    t_bad_addr();
    t_abort();
    chk("R11 pull-down only with SCL low", r11_bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule